// File: doc/BRIEF.md
# Three-Port Parallel I/O Controller

This block is a parallel I/O controller attached to a host bus. It has three 8-bit ports, A, B and C, and one control register. The host reaches them through a 2-bit address with active-low chip select, read and write strobes. It uses separate 8-bit buses for write data and read data. Each port has its own input pins, output pins and output enables. Ports A and B have one enable each. Port C has one enable per bit, driven per nibble.

The host sets the direction of port A, port B and each half of port C with a mode word written to the control address. Data written to a port is always kept in that port's output latch. The latch value appears on the output pins whatever the direction, and the enable tells the pad whether to drive it. A command word written to the same control address can set or clear one port C bit at a time. Only basic input/output operation is performed. Mode words that select the handshake modes are stored and read back, and change nothing else.

Top module: `ppi_core`

## Requirements
- R1: After an active-high `rst`, a read of address 3 returns 0x9B. All output enables are low, and `pa_out`, `pb_out` and `pc_out` are 0x00.
- R2: A write takes effect once, on the rising clock edge where `cs_n` is low, `wr_n` is high and `wr_n` was low at the previous edge. `addr` and `din` are sampled at that edge. Holding `wr_n` low changes nothing.
- R3: Writes to address 0, 1 and 2 load the output latch of port A, B and C. `pa_out`, `pb_out` and `pc_out` always show these latches.
- R4: A write to address 3 with bit 7 = 1 is a mode word that sets the directions, where 1 means input and 0 means output. Bit 4 sets port A, bit 1 port B, bit 3 the upper nibble of port C and bit 0 its lower nibble. `pa_oe` and `pb_oe` are high exactly when their port is an output.
- R5: `pc_oe[7:4]` all follow the upper nibble direction of port C, and `pc_oe[3:0]` all follow the lower nibble direction.
- R6: A read of an output port returns its latch, and a read of an input port returns its input pins. Port C decides this for each nibble separately.
- R7: `dout` is 0x00 whenever `cs_n` or `rd_n` is high.
- R8: A read of address 3 returns the last mode word with bit 7 forced to 1. Mode bits 6:5 and 2 are stored and have no other effect.
- R9: A mode word leaves all three output latches unchanged.
- R10: A write to address 3 with bit 7 = 0 is a single-bit command. Bits 3:1 select bit 0 to 7 of the port C latch, and bit 0 is the new value. The command changes no other bit and leaves the control register unchanged. It also acts when the selected bit is an input.
- R11: A write strobe with `cs_n` high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 2 | Register select: 0 = A, 1 = B, 2 = C, 3 = control |
| din | input | 8 | Write data from host |
| dout | output | 8 | Read data to host |
| pa_in | input | 8 | Port A input pins |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 1 | Port A output enable |
| pb_in | input | 8 | Port B input pins |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 1 | Port B output enable |
| pc_in | input | 8 | Port C input pins |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-bit output enable |

## Verification
The input pins carry values that differ from every latch value. This shows on each read whether the data came from the pins or from the latch. The direction words are chosen to give mixed nibble settings on port C, so a read returns half pin data and half latch data, which exposes a swapped or merged nibble. Single-bit commands are aimed at a bit that is an input and at a bit that is an output. This separates a command that acts on the latch from one that acts on the read path. A mode word with all handshake bits set shows that those bits are stored without side effects. Held and deselected strobes show that a write commits only once, and only with chip select low.

// File: rtl/ppi_pkg.sv
package ppi_pkg;
    localparam int PW  = 8;
    localparam int AW  = 2;
    localparam int HW  = PW / 2;
    localparam int IXW = $clog2(PW);

    localparam logic [AW-1:0] SEL_A   = 2'd0;
    localparam logic [AW-1:0] SEL_B   = 2'd1;
    localparam logic [AW-1:0] SEL_C   = 2'd2;
    localparam logic [AW-1:0] SEL_CTL = 2'd3;

    // control word bit positions (1 = input)
    localparam int B_DIR_CL = 0;
    localparam int B_DIR_B  = 1;
    localparam int B_DIR_CU = 3;
    localparam int B_DIR_A  = 4;
    localparam int B_KIND   = 7;

    localparam logic [PW-2:0] CTL_RST = 7'h1B;

    typedef struct packed {
        logic [PW-2:0] ctl;
        logic [PW-1:0] lat_a;
        logic [PW-1:0] lat_b;
        logic [PW-1:0] lat_c;
    } ppi_state_t;
endpackage

// File: rtl/ppi_wr_strobe.sv
module ppi_wr_strobe (
    input  logic clk,
    input  logic rst,
    input  logic cs_n,
    input  logic wr_n,
    output logic commit
);
    logic wr_n_d, wr_n_q;

    always_comb begin
        wr_n_d = wr_n;
        commit = !cs_n && !wr_n_q && wr_n;
    end

    always_ff @(posedge clk) begin
        if (rst) wr_n_q <= 1'b1;
        else     wr_n_q <= wr_n_d;
    end
endmodule

// File: rtl/ppi_regfile.sv
module ppi_regfile
    import ppi_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          commit,
    input  logic [AW-1:0] addr,
    input  logic [PW-1:0] din,
    output ppi_state_t    st
);
    ppi_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (commit) begin
            case (addr)
                SEL_A:   st_d.lat_a = din;
                SEL_B:   st_d.lat_b = din;
                SEL_C:   st_d.lat_c = din;
                default: begin
                    if (din[B_KIND]) st_d.ctl = din[PW-2:0];
                    else             st_d.lat_c[din[IXW:1]] = din[0];
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.ctl   <= CTL_RST;
            st_q.lat_a <= '0;
            st_q.lat_b <= '0;
            st_q.lat_c <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;
endmodule

// File: rtl/ppi_rd_mux.sv
module ppi_rd_mux
    import ppi_pkg::*;
(
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  ppi_state_t    st,
    input  logic [PW-1:0] pa_in,
    input  logic [PW-1:0] pb_in,
    input  logic [PW-1:0] pc_in,
    output logic [PW-1:0] dout
);
    logic [PW-1:0] c_view;
    logic [1:0]    c_dir;

    assign c_dir = {st.ctl[B_DIR_CU], st.ctl[B_DIR_CL]};

    for (genvar n = 0; n < 2; n++) begin : g_nib
        assign c_view[n*HW +: HW] = c_dir[n] ? pc_in[n*HW +: HW] : st.lat_c[n*HW +: HW];
    end

    always_comb begin
        dout = '0;
        if (rd_en) begin
            case (addr)
                SEL_A:   dout = st.ctl[B_DIR_A] ? pa_in : st.lat_a;
                SEL_B:   dout = st.ctl[B_DIR_B] ? pb_in : st.lat_b;
                SEL_C:   dout = c_view;
                default: dout = {1'b1, st.ctl};
            endcase
        end
    end
endmodule

// File: rtl/ppi_core.sv
module ppi_core
    import ppi_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          cs_n,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic [AW-1:0] addr,
    input  logic [PW-1:0] din,
    output logic [PW-1:0] dout,
    input  logic [PW-1:0] pa_in,
    output logic [PW-1:0] pa_out,
    output logic          pa_oe,
    input  logic [PW-1:0] pb_in,
    output logic [PW-1:0] pb_out,
    output logic          pb_oe,
    input  logic [PW-1:0] pc_in,
    output logic [PW-1:0] pc_out,
    output logic [PW-1:0] pc_oe
);
    logic       commit;
    ppi_state_t st;

    ppi_wr_strobe u_strobe (
        .clk    (clk),
        .rst    (rst),
        .cs_n   (cs_n),
        .wr_n   (wr_n),
        .commit (commit)
    );

    ppi_regfile u_regs (
        .clk    (clk),
        .rst    (rst),
        .commit (commit),
        .addr   (addr),
        .din    (din),
        .st     (st)
    );

    ppi_rd_mux u_rd (
        .rd_en (!cs_n && !rd_n),
        .addr  (addr),
        .st    (st),
        .pa_in (pa_in),
        .pb_in (pb_in),
        .pc_in (pc_in),
        .dout  (dout)
    );

    assign pa_out = st.lat_a;
    assign pb_out = st.lat_b;
    assign pc_out = st.lat_c;
    assign pa_oe  = !st.ctl[B_DIR_A];
    assign pb_oe  = !st.ctl[B_DIR_B];
    assign pc_oe  = {{HW{!st.ctl[B_DIR_CU]}}, {HW{!st.ctl[B_DIR_CL]}}};
endmodule

// File: rtl/ppi_core_chk.sv
module ppi_core_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic       rd_n,
    input logic       wr_n,
    input logic [1:0] addr,
    input logic [7:0] din,
    input logic [7:0] dout,
    input logic [7:0] pa_out,
    input logic [7:0] pb_out,
    input logic [7:0] pc_out,
    input logic       pa_oe,
    input logic       pb_oe,
    input logic [7:0] pc_oe
);
    logic wr_prev;
    logic wr_go;

    always_ff @(posedge clk) begin
        if (rst) wr_prev <= 1'b1;
        else     wr_prev <= wr_n;
    end

    assign wr_go = !cs_n && !wr_prev && wr_n;

    AST_DOUT_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> dout == 8'h00); // R7

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_go |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out)
                    && $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe))); // R2

    AST_PORT_A_LOAD: assert property (@(posedge clk) disable iff (rst)
        (wr_go && addr == 2'd0) |=> pa_out == $past(din)); // R3

    AST_MODE_DIR_A: assert property (@(posedge clk) disable iff (rst)
        (wr_go && addr == 2'd3 && din[7]) |=> pa_oe == !$past(din[4])); // R4

    AST_MODE_KEEPS_LATCH: assert property (@(posedge clk) disable iff (rst)
        (wr_go && addr == 2'd3 && din[7]) |=>
            ($stable(pa_out) && $stable(pb_out) && $stable(pc_out))); // R9

    AST_BITCMD_SCOPE: assert property (@(posedge clk) disable iff (rst)
        (wr_go && addr == 2'd3 && !din[7]) |=>
            ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)
             && $stable(pa_out) && $stable(pb_out)
             && $countones(pc_out ^ $past(pc_out)) <= 1)); // R10

    AST_NIBBLE_OE: assert property (@(posedge clk) disable iff (rst)
        ((pc_oe[7:4] == 4'h0 || pc_oe[7:4] == 4'hF)
         && (pc_oe[3:0] == 4'h0 || pc_oe[3:0] == 4'hF))); // R5
endmodule

bind ppi_core ppi_core_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .addr   (addr),
    .din    (din),
    .dout   (dout),
    .pa_out (pa_out),
    .pb_out (pb_out),
    .pc_out (pc_out),
    .pa_oe  (pa_oe),
    .pb_oe  (pb_oe),
    .pc_oe  (pc_oe)
);

// File: tb/ppi_core_tb.sv
module ppi_core_tb;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0] addr = 2'd0;
    logic [7:0] din = 8'h00;
    logic [7:0] dout, pa_out, pb_out, pc_out, pc_oe;
    logic       pa_oe, pb_oe;
    logic [7:0] pa_in = 8'h3C, pb_in = 8'hC3, pc_in = 8'h5A;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ppi_core u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .addr(addr), .din(din), .dout(dout),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    // {is_write, addr, data, expected read}
    localparam int NV = 24;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 2'd0, 8'hA5, 8'h00},
        {1'b1, 2'd1, 8'h96, 8'h00},
        {1'b1, 2'd2, 8'hE1, 8'h00},
        {1'b0, 2'd0, 8'h00, 8'h3C},   // R6 input reads pins
        {1'b0, 2'd2, 8'h00, 8'h5A},
        {1'b1, 2'd3, 8'h8A, 8'h00},   // R4
        {1'b0, 2'd0, 8'h00, 8'hA5},   // R9 latch kept
        {1'b0, 2'd1, 8'h00, 8'hC3},
        {1'b0, 2'd2, 8'h00, 8'h51},   // R6 mixed nibbles
        {1'b0, 2'd3, 8'h00, 8'h8A},   // R8
        {1'b1, 2'd3, 8'h91, 8'h00},
        {1'b0, 2'd0, 8'h00, 8'h3C},
        {1'b0, 2'd1, 8'h00, 8'h96},
        {1'b0, 2'd2, 8'h00, 8'hEA},
        {1'b1, 2'd3, 8'h07, 8'h00},   // R10 set bit3 while input
        {1'b0, 2'd2, 8'h00, 8'hEA},
        {1'b0, 2'd3, 8'h00, 8'h91},   // R10 control unchanged
        {1'b1, 2'd3, 8'h0C, 8'h00},   // R10 clear bit6 while output
        {1'b0, 2'd2, 8'h00, 8'hAA},
        {1'b1, 2'd3, 8'hE4, 8'h00},   // R8 handshake bits, all out
        {1'b0, 2'd3, 8'h00, 8'hE4},
        {1'b0, 2'd2, 8'h00, 8'hA9},   // R10 bit3 now visible
        {1'b0, 2'd0, 8'h00, 8'hA5},
        {1'b0, 2'd1, 8'h00, 8'h96}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; din = d; cs_n = 1'b0; wr_n = 1'b0;
        @(negedge clk);
        wr_n = 1'b1;
        @(negedge clk);
        cs_n = 1'b1;
    endtask

    task automatic do_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        addr = a; cs_n = 1'b0; rd_n = 1'b0;
        #(CLK_PERIOD/4);
        d = dout;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        do_read(2'd3, rv);
        check("R1 ctl", rv, 8'h9B);
        check("R1 oe", {pa_oe, pb_oe, 6'd0} | pc_oe, 8'h00);
        check("R1 latches", pa_out | pb_out | pc_out, 8'h00);
        // R7 idle bus
        @(negedge clk); addr = 2'd3; cs_n = 1'b0; rd_n = 1'b1;
        #(CLK_PERIOD/4); check("R7 rd_n high", dout, 8'h00);
        @(negedge clk); cs_n = 1'b1; rd_n = 1'b0;
        #(CLK_PERIOD/4); check("R7 cs_n high", dout, 8'h00);
        @(negedge clk); rd_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][18]) begin
                do_write(VEC[i][17:16], VEC[i][15:8]);
            end else begin
                do_read(VEC[i][17:16], rv);
                check($sformatf("R6/R8/R10 vec%0d", i), rv, VEC[i][7:0]);
            end
        end

        // R3/R4/R5 pins and enables after all-output mode
        @(negedge clk);
        check("R4 oe A/B", {6'd0, pa_oe, pb_oe}, 8'h03);
        check("R5 pc_oe", pc_oe, 8'hFF);
        check("R3 pa_out", pa_out, 8'hA5);
        check("R3 pc_out", pc_out, 8'hA9);

        // R5 split nibble enables: C upper in, C lower out, A in, B out
        do_write(2'd3, 8'h98);
        @(negedge clk);
        check("R5 pc_oe split", pc_oe, 8'h0F);
        check("R4 oe split", {6'd0, pa_oe, pb_oe}, 8'h01);
        check("R3 pb_out with port output", pb_out, 8'h96);

        // R11 strobe without chip select
        @(negedge clk); addr = 2'd0; din = 8'h00; cs_n = 1'b1; wr_n = 1'b0;
        @(negedge clk); wr_n = 1'b1;
        @(negedge clk);
        check("R11 ignored", pa_out, 8'hA5);

        // R2 held strobe does not commit, rising edge commits once
        @(negedge clk); addr = 2'd1; din = 8'h11; cs_n = 1'b0; wr_n = 1'b0;
        repeat (4) @(negedge clk);
        check("R2 held low", pb_out, 8'h96);
        wr_n = 1'b1;
        @(negedge clk);
        check("R2 committed", pb_out, 8'h11);
        din = 8'h22;
        repeat (2) @(negedge clk);
        check("R2 once", pb_out, 8'h11);
        cs_n = 1'b1;

        // R1 reset again restores state
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
        check("R1 latch cleared", pb_out, 8'h00);
        do_read(2'd3, rv);
        check("R1 ctl again", rv, 8'h9B);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule